// File: doc/BRIEF.md
# Prescaled Free-Running Timebase Counter

This block is a 16-bit up-counter that serves as a shared time reference for compare and capture channels elsewhere on the chip. An internal prescaler divides the system clock by 4, 16, 32 or 64, as chosen by a 2-bit field. Each time the prescaler expires it raises a one-cycle `tick` strobe, and the count advances by one. Other channels can either sample the count or follow the strobe.

Software reaches the block through a plain register port. Writes land on the rising clock edge. Reads are combinational. The port carries no stream traffic, so no valid/ready handshake is used and there is no back-pressure.

The count can be zeroed in three ways: system reset, a self-clearing soft-clear bit, and, when the compare-clear mode is selected, a match against compare register 0. A wrap from 0xFFFF sets a sticky overflow flag. A compare-clear match sets a sticky match flag. One interrupt line reports the overflow flag in plain mode and the match flag in compare-clear mode.

Top module: `tbase_timer`

## Requirements
- R1: After reset, `count` is 0x0000, `tick` and `irq` are 0, and the control register (address 0) reads 0x0000.
- R2: While running, `tick` is high for exactly one cycle in every N clocks. N is 4, 16, 32 or 64 for a control field value bits[2:1] of 0, 1, 2 or 3. Each tick increments `count` by one in the following cycle.
- R3: While the run bit (control bit 0) is 0, `tick` stays low and `count` holds its value.
- R4: Writing control with bit 4 set zeroes `count` and restarts the prescaler. Bit 4 is not stored and reads back as 0.
- R5: With compare-clear mode selected (control bit 3 = 1), the count holds the compare value for one full tick period. The tick that ends that period loads 0x0000 and sets the sticky match flag (control bit 6).
- R6: With compare-clear mode off, a match with the compare register neither clears the count nor sets the match flag.
- R7: A tick while the count is 0x0000FFFF's low half 0xFFFF wraps the count to 0x0000 and sets the sticky overflow flag (control bit 5). Writing 1 to bit 5 clears the flag. Writing 0 to bit 5 leaves it set.
- R8: `irq` equals the interrupt-enable bit (control bit 7) ANDed with the match flag when compare-clear mode is on, or with the overflow flag when that mode is off.
- R9: Writing a new value into the ratio field, or loading the count, restarts the prescaler. The first tick then arrives a full N clocks after the write edge.
- R10: Writing address 2 loads `count` with the written data.
- R11: `rd_data` returns control at address 0, compare register 0 at address 1, the count at address 2, and 0 at address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 compare, 2 count) |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Read data, combinational |
| count | output | 16 | Current timebase count |
| tick | output | 1 | One-cycle strobe when the prescaler expires |
| irq | output | 1 | Interrupt request |

## Verification
The table-driven loop runs the counter at each of the four ratios. It measures both the delay from a restart to the first tick and the spacing between later ticks, so a wrong divisor or an off-by-one in the restart shows up as a wrong cycle count.

Directed patterns start from a preset count just below 0xFFFF and just below the compare value. These separate wrap-and-overflow from compare-clear, and separate mode-on from mode-off behaviour at the same match. The patterns also show whether the count lingers at the compare value for a full tick period.

Flag and interrupt checks toggle the enable and mode bits, and write both 0 and 1 to the flag bits. This separates sticky write-one-to-clear behaviour from plain storage.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
  localparam int DIV_W = 6;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CMP  = 2'd1;
  localparam logic [1:0] A_CNT  = 2'd2;
  localparam int B_RUN  = 0;
  localparam int B_SEL  = 1;
  localparam int B_MODE = 3;
  localparam int B_CLR  = 4;
  localparam int B_OVF  = 5;
  localparam int B_MAT  = 6;
  localparam int B_IE   = 7;

  function automatic logic [DIV_W-1:0] limit_of(input logic [1:0] sel);
    case (sel)
      2'd0:    limit_of = DIV_W'(3);
      2'd1:    limit_of = DIV_W'(15);
      2'd2:    limit_of = DIV_W'(31);
      default: limit_of = DIV_W'(63);
    endcase
  endfunction
endpackage

// File: rtl/tbase_prescaler.sv
module tbase_prescaler
  import tbase_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] sel,
  input  logic       restart,
  output logic       tick
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] lim;

  assign lim  = limit_of(sel);
  assign tick = run && !restart && (div_q == lim);

  always_ff @(posedge clk) begin
    if (!rst_n)                   div_q <= '0;
    else if (!run || restart)     div_q <= '0;
    else if (div_q == lim)        div_q <= '0;
    else                          div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/tbase_counter.sv
module tbase_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         mode,
  input  logic [W-1:0] cmp,
  output logic [W-1:0] count,
  output logic         ovf_evt,
  output logic         cmp_evt
);
  logic hit;

  assign hit     = mode && (count == cmp);
  assign cmp_evt = tick && hit;
  assign ovf_evt = tick && !hit && (&count);

  always_ff @(posedge clk) begin
    if (!rst_n)     count <= '0;
    else if (clr)   count <= '0;
    else if (ld)    count <= ld_val;
    else if (tick)  count <= hit ? '0 : count + 1'b1;
  end
endmodule

// File: rtl/tbase_regs.sv
module tbase_regs
  import tbase_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   rd_addr,
  output logic [W-1:0] rd_data,
  input  logic [W-1:0] count,
  input  logic         ovf_evt,
  input  logic         cmp_evt,
  output logic         run,
  output logic [1:0]   sel,
  output logic         mode,
  output logic [W-1:0] cmp,
  output logic         soft_clr,
  output logic         ld,
  output logic         restart,
  output logic         ovf_flag,
  output logic         cmp_flag,
  output logic         irq
);
  logic ie;
  logic wr_ctrl;
  logic sel_chg;
  logic [7:0] ctrl_view;

  assign wr_ctrl  = wr_en && (wr_addr == A_CTRL);
  assign ld       = wr_en && (wr_addr == A_CNT);
  assign soft_clr = wr_ctrl && wr_data[B_CLR];
  assign sel_chg  = wr_ctrl && (wr_data[B_SEL+1:B_SEL] != sel);
  assign restart  = soft_clr || sel_chg || ld;
  assign irq      = ie && (mode ? cmp_flag : ovf_flag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0; sel <= 2'd0; mode <= 1'b0; ie <= 1'b0;
      cmp <= '0; ovf_flag <= 1'b0; cmp_flag <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        run  <= wr_data[B_RUN];
        sel  <= wr_data[B_SEL+1:B_SEL];
        mode <= wr_data[B_MODE];
        ie   <= wr_data[B_IE];
      end
      if (wr_en && (wr_addr == A_CMP)) cmp <= wr_data;
      ovf_flag <= (ovf_flag && !(wr_ctrl && wr_data[B_OVF])) || ovf_evt;
      cmp_flag <= (cmp_flag && !(wr_ctrl && wr_data[B_MAT])) || cmp_evt;
    end
  end

  assign ctrl_view = {ie, cmp_flag, ovf_flag, 1'b0, mode, sel, run};

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = {{(W-8){1'b0}}, ctrl_view};
      A_CMP:   rd_data = cmp;
      A_CNT:   rd_data = count;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/tbase_timer.sv
module tbase_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic [CNT_W-1:0] count,
  output logic             tick,
  output logic             irq
);
  logic             run, mode, soft_clr, ld, restart;
  logic             ovf_flag, cmp_flag, ovf_evt, cmp_evt;
  logic [1:0]       sel;
  logic [CNT_W-1:0] cmp;

  tbase_regs #(.W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .count(count), .ovf_evt(ovf_evt), .cmp_evt(cmp_evt),
    .run(run), .sel(sel), .mode(mode), .cmp(cmp),
    .soft_clr(soft_clr), .ld(ld), .restart(restart),
    .ovf_flag(ovf_flag), .cmp_flag(cmp_flag), .irq(irq)
  );

  tbase_prescaler u_psc (
    .clk(clk), .rst_n(rst_n), .run(run), .sel(sel),
    .restart(restart), .tick(tick)
  );

  tbase_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr(soft_clr), .ld(ld),
    .ld_val(wr_data), .mode(mode), .cmp(cmp), .count(count),
    .ovf_evt(ovf_evt), .cmp_evt(cmp_evt)
  );
endmodule

// File: rtl/tbase_timer_chk.sv
module tbase_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic [W-1:0] count,
  input logic [W-1:0] cmp,
  input logic         mode,
  input logic         run,
  input logic         ovf_flag,
  input logic         cmp_flag,
  input logic         wr_en,
  input logic [1:0]   wr_addr
);
  logic cnt_wr;
  assign cnt_wr = wr_en && (wr_addr == 2'd0 || wr_addr == 2'd2);

  assert_tick_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  assert_tick_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !mode) |=> (count == W'($past(count) + 1'b1)));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(count));

  assert_cmp_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode && count == cmp) |=> (count == '0 && cmp_flag));

  assert_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (&count) && !(mode && (&cmp))) |=> ovf_flag);
endmodule

bind tbase_timer tbase_timer_chk #(.W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .count(count), .cmp(cmp),
  .mode(mode), .run(run), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag),
  .wr_en(wr_en), .wr_addr(wr_addr)
);

// File: tb/tbase_timer_tb.sv
module tbase_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [1:0]  rd_addr = 2'd0;
  logic [15:0] rd_data, count;
  logic        tick, irq;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  localparam logic [15:0] VEC_CTRL [4] = '{16'h0001, 16'h0003, 16'h0005, 16'h0007};
  localparam int          VEC_N    [4] = '{4, 16, 32, 64};

  tbase_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .count(count), .tick(tick), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  // counts negedges from the current one until tick is seen high
  task automatic wait_tick(output int n);
    n = 1;
    while (!tick && n < 200) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step;
    // R1 reset state
    check("R1 count", count, 0);
    check("R1 tick", tick, 0);
    check("R1 irq", irq, 0);
    rd(2'd0, v); check("R1 ctrl", v, 0);

    // table walk: every ratio, restart delay and steady spacing (R2, R9)
    for (int i = 0; i < 4; i++) begin
      wr(2'd0, VEC_CTRL[i]);
      wr(2'd2, 16'h0000);
      wait_tick(n); check("R9 first tick delay", n, VEC_N[i]);
      step; check("R2 count after tick", count, 1);
      wait_tick(n); check("R2 tick spacing", n, VEC_N[i]);
      step; check("R2 count second tick", count, 2);
    end

    // R9 ratio change restarts prescaler mid-period
    wr(2'd0, 16'h0001);
    wr(2'd2, 16'h0000);
    step;
    wr(2'd0, 16'h0003);
    wait_tick(n); check("R9 ratio change delay", n, 16);

    // R10 load and R11 readback
    wr(2'd0, 16'h0000);
    wr(2'd2, 16'hABCD);
    check("R10 count load", count, 16'hABCD);
    rd(2'd2, v); check("R11 read count", v, 16'hABCD);
    wr(2'd1, 16'h0005);
    rd(2'd1, v); check("R11 read compare", v, 5);
    rd(2'd3, v); check("R11 read reserved", v, 0);

    // R3 stopped counter holds
    n = 0;
    for (int k = 0; k < 100; k++) begin
      step;
      if (tick) n++;
    end
    check("R3 no tick while stopped", n, 0);
    check("R3 count held", count, 16'hABCD);

    // R4 soft clear
    wr(2'd0, 16'h0001);
    wr(2'd2, 16'h1234);
    wr(2'd0, 16'h0011);
    check("R4 count cleared", count, 0);
    rd(2'd0, v); check("R4 clear bit not stored", v[4], 0);
    wait_tick(n); check("R4 prescaler restarted", n, 4);

    // R7 overflow, irq enable off then on (R8)
    wr(2'd2, 16'hFFFE);
    wait_tick(n); step; check("R7 count 0xFFFF", count, 16'hFFFF);
    wait_tick(n); step; check("R7 wrap to zero", count, 0);
    rd(2'd0, v); check("R7 overflow flag set", v[5], 1);
    check("R8 irq masked", irq, 0);
    wr(2'd0, 16'h0081);
    check("R8 irq on overflow", irq, 1);
    wr(2'd0, 16'h0081);
    rd(2'd0, v); check("R7 write 0 keeps flag", v[5], 1);
    wr(2'd0, 16'h00A1);
    rd(2'd0, v); check("R7 write 1 clears flag", v[5], 0);
    check("R8 irq drops", irq, 0);

    // R6 match with mode off passes through
    wr(2'd1, 16'h0005);
    wr(2'd2, 16'h0004);
    wait_tick(n); step; check("R6 count reaches compare", count, 5);
    wait_tick(n); step; check("R6 count passes compare", count, 6);
    rd(2'd0, v); check("R6 no match flag", v[6], 0);

    // R5 compare clear with irq from match flag (R8)
    wr(2'd0, 16'h0089);
    wr(2'd2, 16'h0003);
    wait_tick(n); step; check("R5 count 4", count, 4);
    wait_tick(n); step; check("R5 count at compare", count, 5);
    step; step;
    check("R5 compare value held", count, 5);
    check("R8 no irq before match", irq, 0);
    wait_tick(n); step; check("R5 cleared after period", count, 0);
    rd(2'd0, v); check("R5 match flag", v[6], 1);
    check("R5 overflow flag clear", v[5], 0);
    check("R8 irq on match", irq, 1);
    wr(2'd0, 16'h00C9);
    check("R8 irq after match clear", irq, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule